// File: doc/BRIEF.md
# Waveform Head Cache and Streaming Playback Engine

This block feeds a dual-channel waveform output at one eighth of the sample rate. Every clock it emits a beat of eight samples per channel, together with two marker bits per channel. Waveform data comes from two places:

- **Block cache.** The start of each waveform lives in an on-chip cache organised as fixed-size blocks. Playback can therefore begin without waiting on slow main memory.
- **Tail FIFO.** A short waveform (at most two blocks) is played entirely from the cache. A long waveform has only its two-block head cached, and everything after the head is streamed through a FIFO. A main-memory read port fills that FIFO.

The block is driven by explicit commands. A beat write port loads cache content, and a tail port pushes streamed beats. A play command names a starting block and a length in samples. A zero-play command names only a length and produces silence without touching any storage.

A single-entry command slot sits behind the active command. This lets consecutive commands play back to back with no idle cycle between them. A playback is held until the cache blocks of its head have been completely written. Illegal lengths are dropped with an error pulse. A tail FIFO that runs dry produces zero beats and an underrun pulse instead of stalling.

Top module: `wave_cache_player`

## Requirements
- R1: After reset, out_valid, err_len and underrun are 0, cmd_ready and tail_ready are 1, and the output fields are zero.
- R2: The cache holds NBLK blocks of BLK_SAMP samples, stored as beats of eight. Waveform beat p of a play starting at block b reads cache beat address (b*BLK_SAMP/8 + p) mod (NBLK*BLK_SAMP/8).
  - Sample i of a beat occupies bits [i*SW +: SW] of its channel word.
  - out_mark bits [1:0] belong to channel 0 and bits [3:2] to channel 1.
  - While out_valid is 0, every output field is zero.
- R3: A play of at most 2*BLK_SAMP samples is read wholly from the cache. A play starting in the last block wraps to block 0.
- R4: A play longer than 2*BLK_SAMP samples takes its first BLK_SAMP/4 beats from the cache and every later beat from the tail FIFO, in push order.
- R5: A cache block becomes full when its last beat is written and empty when its first beat is written. A play emits no beat until every block of its head is full: one block if its length is at most BLK_SAMP, otherwise two.
- R6: A play length is legal only if it is at least 32 and a multiple of 16. For an illegal length, err_len pulses for one cycle after acceptance, the command is dropped and no beat results.
- R7: A command accepted while another command plays emits its first beat in the cycle right after the previous command's last beat. Consecutive beats of one command are likewise contiguous.
- R8: A zero-play of n samples (n at least 1) emits ceil(n/8) beats with zero data and markers and pops no FIFO entry. A zero-play with n = 0 raises err_len.
- R9: out_mask is 8'hFF on every beat except the final beat of a command whose length n is not a multiple of 8. That beat has only its low (n mod 8) bits set.
- R10: If a tail beat is due while the FIFO is empty, the beat is emitted as zeros with underrun high in the same cycle, and the play advances past it.
- R11: tail_ready is 0 exactly while the FIFO holds FDEPTH beats, and the FIFO never exceeds FDEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at one eighth of the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Cache beat write strobe |
| wr_addr | input | $clog2(NBLK*BLK_SAMP/8) | Cache beat address (block index in upper bits) |
| wr_ch0 | input | 8*SW | Channel 0 samples of written beat |
| wr_ch1 | input | 8*SW | Channel 1 samples of written beat |
| wr_mark | input | 4 | Marker bits of written beat |
| tail_valid | input | 1 | Tail beat offered by main-memory read port |
| tail_ready | output | 1 | FIFO can accept a tail beat |
| tail_ch0 | input | 8*SW | Channel 0 samples of tail beat |
| tail_ch1 | input | 8*SW | Channel 1 samples of tail beat |
| tail_mark | input | 4 | Marker bits of tail beat |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command slot free |
| cmd_zero | input | 1 | 1 for a zero-play command |
| cmd_blk | input | $clog2(NBLK) | Starting cache block of a play |
| cmd_len | input | LW | Length in samples |
| out_valid | output | 1 | Output beat valid |
| out_ch0 | output | 8*SW | Channel 0 output samples |
| out_ch1 | output | 8*SW | Channel 1 output samples |
| out_mark | output | 4 | Output marker bits |
| out_mask | output | 8 | Per-sample valid mask |
| err_len | output | 1 | Illegal-length pulse |
| underrun | output | 1 | Tail FIFO starvation pulse |

## Verification
Two functions overlap in the same cycle during the gapless checks:

- **End of one command and start of the next.** The finishing beat of one command coincides with the promotion of the queued command. This is provoked by issuing two plays and then a zero-play of 13 samples while the first still runs. The bench judges it by requiring the recorded cycle numbers of all twelve beats to be consecutive, with the zero beats carrying the padded final mask.
- **Beat emission and cache writes.** A held play waits in the active slot while the bench rewrites its block beat by beat. The bench requires silence until the block's last beat lands, and then the exact rewritten data.

// File: rtl/wave_cache_player.sv
module wave_cache_player #(
  parameter int SW       = 16,
  parameter int NBLK     = 8,
  parameter int BLK_SAMP = 64,
  parameter int FDEPTH   = 8,
  parameter int LW       = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [$clog2(NBLK*BLK_SAMP/8)-1:0]   wr_addr,
  input  logic [8*SW-1:0]                      wr_ch0,
  input  logic [8*SW-1:0]                      wr_ch1,
  input  logic [3:0]                           wr_mark,
  input  logic                                 tail_valid,
  output logic                                 tail_ready,
  input  logic [8*SW-1:0]                      tail_ch0,
  input  logic [8*SW-1:0]                      tail_ch1,
  input  logic [3:0]                           tail_mark,
  input  logic                                 cmd_valid,
  output logic                                 cmd_ready,
  input  logic                                 cmd_zero,
  input  logic [$clog2(NBLK)-1:0]              cmd_blk,
  input  logic [LW-1:0]                        cmd_len,
  output logic                                 out_valid,
  output logic [8*SW-1:0]                      out_ch0,
  output logic [8*SW-1:0]                      out_ch1,
  output logic [3:0]                           out_mark,
  output logic [7:0]                           out_mask,
  output logic                                 err_len,
  output logic                                 underrun
);
  localparam int BB  = BLK_SAMP / 8;
  localparam int CB  = NBLK * BB;
  localparam int AW  = $clog2(CB);
  localparam int BW  = $clog2(NBLK);
  localparam int OW  = $clog2(BB);
  localparam int WW  = 4 + 16 * SW;
  localparam int FAW = $clog2(FDEPTH);

  logic [WW-1:0] cache [CB];
  logic [WW-1:0] fifo  [FDEPTH];
  logic [NBLK-1:0] blk_full;
  logic [FAW-1:0] rp, wp;
  logic [FAW:0]   fcnt;

  logic          nxt_v, nxt_zero;
  logic [BW-1:0] nxt_blk;
  logic [LW-1:0] nxt_len;

  logic          cur_v, cur_zero;
  logic [BW-1:0] cur_blk;
  logic [LW-1:0] cur_len, cur_nb, pos;

  logic          legal, head_ok, emit, last, tail_beat, starve, pop, push, promote;
  logic [AW-1:0] rd_addr;
  logic [WW-1:0] beat_word;
  logic [7:0]    mask_last;
  logic [LW-1:0] nxt_nb;

  assign cmd_ready  = !nxt_v;
  assign tail_ready = (fcnt != (FAW+1)'(FDEPTH));
  assign push       = tail_valid && tail_ready;

  assign legal   = cmd_zero ? (cmd_len != '0)
                            : (cmd_len >= LW'(32) && cmd_len[3:0] == 4'd0);
  assign head_ok = blk_full[cur_blk] &&
                   (cur_len <= LW'(BLK_SAMP) || blk_full[cur_blk + 1'b1]);
  assign emit    = cur_v && (cur_zero || pos != '0 || head_ok);
  assign last    = (pos == cur_nb - 1'b1);
  assign tail_beat = !cur_zero && cur_len > LW'(2*BLK_SAMP) && pos >= LW'(2*BB);
  assign starve  = emit && tail_beat && fcnt == '0;
  assign pop     = emit && tail_beat && fcnt != '0;
  assign promote = nxt_v && (!cur_v || (emit && last));

  assign rd_addr   = AW'({cur_blk, {OW{1'b0}}}) + pos[AW-1:0];
  assign beat_word = (cur_zero || starve) ? '0 : (tail_beat ? fifo[rp] : cache[rd_addr]);
  assign mask_last = (cur_len[2:0] == 3'd0) ? 8'hFF
                                            : 8'((9'd1 << cur_len[2:0]) - 9'd1);
  assign nxt_nb    = LW'(({1'b0, nxt_len} + (LW+1)'(7)) >> 3);

  always_ff @(posedge clk) begin
    if (wr_en) cache[wr_addr] <= {wr_mark, wr_ch1, wr_ch0};
    if (push)  fifo[wp]       <= {tail_mark, tail_ch1, tail_ch0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_full <= '0;
      rp <= '0; wp <= '0; fcnt <= '0;
    end else begin
      if (wr_en && wr_addr[OW-1:0] == '0)
        blk_full[wr_addr[AW-1:OW]] <= 1'b0;
      if (wr_en && wr_addr[OW-1:0] == OW'(BB-1))
        blk_full[wr_addr[AW-1:OW]] <= 1'b1;
      if (push) wp <= (wp == FAW'(FDEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == FAW'(FDEPTH-1)) ? '0 : rp + 1'b1;
      fcnt <= fcnt + (FAW+1)'(push) - (FAW+1)'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_v <= 1'b0; nxt_zero <= 1'b0; nxt_blk <= '0; nxt_len <= '0;
      cur_v <= 1'b0; cur_zero <= 1'b0; cur_blk <= '0; cur_len <= '0;
      cur_nb <= '0; pos <= '0;
      err_len <= 1'b0;
    end else begin
      err_len <= 1'b0;
      if (cmd_valid && cmd_ready) begin
        if (legal) begin
          nxt_v    <= 1'b1;
          nxt_zero <= cmd_zero;
          nxt_blk  <= cmd_blk;
          nxt_len  <= cmd_len;
        end else begin
          err_len <= 1'b1;
        end
      end
      if (emit) begin
        pos <= pos + 1'b1;
        if (last) cur_v <= 1'b0;
      end
      if (promote) begin
        nxt_v    <= 1'b0;
        cur_v    <= 1'b1;
        cur_zero <= nxt_zero;
        cur_blk  <= nxt_blk;
        cur_len  <= nxt_len;
        cur_nb   <= nxt_nb;
        pos      <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ch0   <= '0;
      out_ch1   <= '0;
      out_mark  <= '0;
      out_mask  <= '0;
      underrun  <= 1'b0;
    end else begin
      out_valid <= emit;
      underrun  <= starve;
      out_ch0   <= emit ? beat_word[8*SW-1:0]       : '0;
      out_ch1   <= emit ? beat_word[16*SW-1:8*SW]   : '0;
      out_mark  <= emit ? beat_word[WW-1:16*SW]     : '0;
      out_mask  <= emit ? (last ? mask_last : 8'hFF) : 8'h00;
    end
  end
endmodule

// File: rtl/wcp_checker.sv
module wcp_checker #(
  parameter int SW     = 16,
  parameter int FDEPTH = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        out_valid,
  input logic [8*SW-1:0]             out_ch0,
  input logic [8*SW-1:0]             out_ch1,
  input logic [3:0]                  out_mark,
  input logic [7:0]                  out_mask,
  input logic                        err_len,
  input logic                        underrun,
  input logic                        nxt_v,
  input logic [$clog2(FDEPTH):0]     fcnt
);
  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_ch0 == '0 && out_ch1 == '0 && out_mark == '0 && out_mask == '0));

  assert_err_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_len |-> !$rose(nxt_v));

  assert_underrun_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (out_valid && out_ch0 == '0 && out_ch1 == '0 && out_mark == '0));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= ($clog2(FDEPTH)+1)'(FDEPTH));

  assert_mask_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask[0] && ((out_mask & (out_mask + 8'd1)) == 8'd0)));
endmodule

bind wave_cache_player wcp_checker #(.SW(SW), .FDEPTH(FDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ch0(out_ch0),
  .out_ch1(out_ch1), .out_mark(out_mark), .out_mask(out_mask),
  .err_len(err_len), .underrun(underrun), .nxt_v(nxt_v), .fcnt(fcnt)
);

// File: tb/tb_wave_cache_player.sv
module tb_wave_cache_player;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int NOBS = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0; logic [5:0] wr_addr = '0;
  logic [127:0] wr_ch0 = '0, wr_ch1 = '0; logic [3:0] wr_mark = '0;
  logic tail_valid = 1'b0, tail_ready;
  logic [127:0] tail_ch0 = '0, tail_ch1 = '0; logic [3:0] tail_mark = '0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_zero = 1'b0;
  logic [2:0] cmd_blk = '0; logic [15:0] cmd_len = '0;
  logic out_valid; logic [127:0] out_ch0, out_ch1; logic [3:0] out_mark;
  logic [7:0] out_mask; logic err_len, underrun;

  wave_cache_player dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, obs_n = 0, errc = 0, urc = 0;
  logic [127:0] o0 [NOBS]; logic [127:0] o1 [NOBS];
  logic [3:0] om [NOBS]; logic [7:0] ok [NOBS]; int oc [NOBS];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n) begin
    if (err_len) errc++;
    if (underrun) urc++;
    if (out_valid && obs_n < NOBS) begin
      o0[obs_n] = out_ch0; o1[obs_n] = out_ch1; om[obs_n] = out_mark;
      ok[obs_n] = out_mask; oc[obs_n] = cyc; obs_n++;
    end
  end

  function automatic logic [127:0] pa(int s);
    logic [127:0] r;
    for (int i = 0; i < 8; i++) r[i*SW +: SW] = {8'(s), 8'(i)};
    return r;
  endfunction
  function automatic logic [127:0] pb(int s);
    logic [127:0] r;
    for (int i = 0; i < 8; i++) r[i*SW +: SW] = {8'(~s), 8'(i)};
    return r;
  endfunction

  task automatic chk(input bit c, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_beat(input int a);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_ch0 = pa(a); wr_ch1 = pb(a); wr_mark = 4'(a);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic push_tail(input int s);
    @(negedge clk);
    tail_valid = 1'b1; tail_ch0 = pa(s); tail_ch1 = pb(s); tail_mark = 4'(s);
    @(negedge clk); tail_valid = 1'b0;
  endtask

  task automatic issue(input bit z, input int blk, input int len);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_zero = z; cmd_blk = 3'(blk); cmd_len = 16'(len);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic wait_obs(input int target);
    for (int t = 0; t < 300 && obs_n < target; t++) @(negedge clk);
  endtask

  task automatic cmp_beat(input int idx, input bit zero, input int seed, input logic [7:0] mk, input string tag);
    logic [127:0] e0, e1; logic [3:0] em;
    e0 = zero ? '0 : pa(seed); e1 = zero ? '0 : pb(seed); em = zero ? 4'd0 : 4'(seed);
    chk(o0[idx] == e0, {tag, " ch0"}, o0[idx], e0);
    chk(o1[idx] == e1, {tag, " ch1"}, o1[idx], e1);
    chk(om[idx] == em, {tag, " mark"}, 128'(om[idx]), 128'(em));
    chk(ok[idx] == mk, {tag, " mask"}, 128'(ok[idx]), 128'(mk));
  endtask

  task automatic t_reset();
    chk(out_valid == 0 && err_len == 0 && underrun == 0, "R1 outputs idle", 128'(out_valid), 0);
    chk(cmd_ready == 1 && tail_ready == 1, "R1 ready high", 128'({cmd_ready, tail_ready}), 3);
    chk(out_ch0 == '0 && out_mask == '0, "R1 fields zero", out_ch0, 0);
  endtask

  task automatic t_short();
    int n0 = obs_n;
    issue(0, 0, 32); wait_obs(n0 + 4);
    chk(obs_n == n0 + 4, "R2 short beat count", 128'(obs_n - n0), 4);
    for (int k = 0; k < 4; k++) cmp_beat(n0 + k, 0, k, 8'hFF, "R2 short play");
  endtask

  task automatic t_wrap();
    int n0 = obs_n;
    issue(0, 7, 128); wait_obs(n0 + 16);
    chk(obs_n == n0 + 16, "R3 wrap beat count", 128'(obs_n - n0), 16);
    for (int k = 0; k < 16; k++) cmp_beat(n0 + k, 0, (56 + k) % 64, 8'hFF, "R3 wrap play");
  endtask

  task automatic t_gapless();
    int n0 = obs_n;
    issue(0, 1, 32); issue(0, 0, 48); issue(1, 0, 13);
    wait_obs(n0 + 12);
    chk(obs_n == n0 + 12, "R7 gapless beat count", 128'(obs_n - n0), 12);
    for (int k = 0; k < 11; k++)
      chk(oc[n0+k+1] == oc[n0+k] + 1, "R7 contiguous beats", 128'(oc[n0+k+1]), 128'(oc[n0+k] + 1));
    for (int k = 0; k < 4; k++) cmp_beat(n0 + k, 0, 8 + k, 8'hFF, "R7 first play");
    for (int k = 0; k < 6; k++) cmp_beat(n0 + 4 + k, 0, k, 8'hFF, "R7 second play");
    cmp_beat(n0 + 10, 1, 0, 8'hFF, "R8 zero beat");
    cmp_beat(n0 + 11, 1, 0, 8'h1F, "R9 padded final mask");
  endtask

  task automatic t_errors();
    int n0 = obs_n, e0 = errc;
    issue(0, 0, 40); issue(0, 0, 16); issue(1, 0, 0);
    repeat (6) @(negedge clk);
    chk(errc == e0 + 3, "R6 R8 error pulses", 128'(errc - e0), 3);
    chk(obs_n == n0, "R6 no output on illegal", 128'(obs_n - n0), 0);
  endtask

  task automatic t_head_wait();
    int n0;
    wr_beat(24);
    n0 = obs_n;
    issue(0, 3, 64);
    repeat (10) @(negedge clk);
    chk(obs_n == n0, "R5 held while block not full", 128'(obs_n - n0), 0);
    for (int a = 25; a < 32; a++) wr_beat(a);
    wait_obs(n0 + 8);
    chk(obs_n == n0 + 8, "R5 beat count after fill", 128'(obs_n - n0), 8);
    for (int k = 0; k < 8; k++) cmp_beat(n0 + k, 0, 24 + k, 8'hFF, "R5 released play");
  endtask

  task automatic t_underrun();
    int n0 = obs_n, u0 = urc;
    issue(0, 4, 160); wait_obs(n0 + 20);
    chk(obs_n == n0 + 20, "R10 beat count", 128'(obs_n - n0), 20);
    for (int k = 0; k < 16; k++) cmp_beat(n0 + k, 0, 32 + k, 8'hFF, "R4 head from cache");
    for (int k = 16; k < 20; k++) cmp_beat(n0 + k, 1, 0, 8'hFF, "R10 starved beat");
    @(negedge clk);
    chk(urc == u0 + 4, "R10 underrun pulses", 128'(urc - u0), 4);
  endtask

  task automatic t_long();
    int n0, u0 = urc;
    for (int k = 0; k < 8; k++) push_tail(100 + k);
    chk(tail_ready == 0, "R11 ready low when full", 128'(tail_ready), 0);
    n0 = obs_n;
    issue(0, 2, 192); wait_obs(n0 + 24);
    chk(obs_n == n0 + 24, "R4 long beat count", 128'(obs_n - n0), 24);
    for (int k = 0; k < 16; k++) cmp_beat(n0 + k, 0, 16 + k, 8'hFF, "R4 long head");
    for (int k = 0; k < 8; k++) cmp_beat(n0 + 16 + k, 0, 100 + k, 8'hFF, "R4 long tail");
    @(negedge clk);
    chk(urc == u0, "R10 no underrun with data", 128'(urc - u0), 0);
    chk(tail_ready == 1, "R11 ready after drain", 128'(tail_ready), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    for (int a = 0; a < 64; a++) wr_beat(a);
    t_short();
    t_wrap();
    t_gapless();
    t_errors();
    t_head_wait();
    t_underrun();
    t_long();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule